// File: doc/BRIEF.md
# Delay Line Calibration Controller

This block supervises a group of delay-line calibrators. When a calibration runs, every calibrator steps a tap counter once per clock and stops when its phase detector reports a level change against the level it held at the start. The number of steps taken is the tap count that spans the reference interval, which is half a clock period at the chosen frequency. Software reads that count back per calibrator and uses it to work out the delay of a single tap.

A small register bus gives access to one control register and to one register per calibrator. Software can start a calibration by hand through a self-clearing start bit. It can also turn on periodic automatic calibration. A calibration result can be blocked from reaching the applied delay, or the applied delay can be driven from a value that software writes. Each calibrator's applied delay leaves the block as an 8-bit field of a flat output vector.

Top module: `dlcal_ctrl`

## Requirements
- R1: Writing 1 to bit 7 of the control register (address 0) while idle starts a calibration. Bit 7 reads 1 from the next cycle until the calibration has finished, then reads 0.
- R2: While bit 6 of the control register is 1, each calibrator's applied delay takes the software delay held in bits [7:0] of its register, two cycles after the control write. A completing calibration does not change it.
- R3: Bit 5 of the control register enables automatic calibration. While it is 0, no calibration starts unless software requests one.
- R4: While bit 4 of the control register is 1, a completing calibration leaves the applied delays unchanged.
- R5: Calibrator i's register is at address i+1. Its bits [31:24] report the last measured count: the number of tap steps taken before the phase detector differed from its level at the start. A change seen on the first active cycle gives 0.
- R6: The count saturates at 255. A saturated result sets the sticky overflow flag in bit 8 of that calibrator's register. The flag stays set until software writes 1 to bit 8 of that register.
- R7: A calibration completes one cycle after every calibrator has finished. At that point bit 7 clears, and if bits 6 and 4 are both 0, each applied delay loads its new count.
- R8: With automatic calibration enabled, a calibration is requested every AUTO_PERIOD cycles, counted from the cycle the enable was written. A request is dropped if a calibration is already running.
- R9: A write of 1 to bit 7 while a calibration is running is ignored and does not restart the measurement.
- R10: After reset, every register reads 0 and all applied delays are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address (0 = control, i+1 = calibrator i) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| pd_in | input | NUM_CAL | Phase-detector level per calibrator |
| delay_out | output | NUM_CAL*8 | Applied delay; calibrator i at bits [8i+7:8i] |

## Verification
A stuck or early busy state shows at once in bit 7 of the control register. It also shows one calibration later as shifted counts in bits [31:24], because the tap counters restart or stop at the wrong cycle. A wrong gate on the applied-delay load shows on delay_out in the cycle after completion. A wrong timer phase moves the rising edge of bit 7 away from cycle AUTO_PERIOD after the enable write. The bench compares the registers and delay_out against its own model on every clock, so any of these faults appears within one cycle of its first visible effect.

// File: rtl/dlcal_pkg.sv
package dlcal_pkg;
    localparam int TAP_W     = 8;
    localparam int DATA_W    = 32;
    localparam int MEAS_LSB  = 24;
    localparam int OVF_BIT   = 8;
    localparam int START_BIT = 7;
    localparam int USESW_BIT = 6;
    localparam int AUTO_BIT  = 5;
    localparam int INH_BIT   = 4;

    typedef logic [TAP_W-1:0] tap_t;

    typedef struct packed {
        logic use_sw;
        logic auto_en;
        logic inhibit;
    } ctrl_t;
endpackage

// File: rtl/dlcal_tap_counter.sv
module dlcal_tap_counter
    import dlcal_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic active_i,
    input  logic pd_i,
    input  logic ovf_clr_i,
    output logic fin_o,
    output tap_t meas_o,
    output logic ovf_o
);
    localparam tap_t TAP_MAX = '1;

    typedef struct packed {
        tap_t cnt;
        tap_t meas;
        logic fin;
        logic ref_lvl;
        logic ovf;
    } tc_st_t;

    tc_st_t st_d, st_q;
    logic   sat_set;

    always_comb begin
        st_d    = st_q;
        sat_set = 1'b0;
        if (start_i) begin
            st_d.cnt     = '0;
            st_d.fin     = 1'b0;
            st_d.ref_lvl = pd_i;
        end else if (active_i && !st_q.fin) begin
            if (pd_i != st_q.ref_lvl) begin
                st_d.fin  = 1'b1;
                st_d.meas = st_q.cnt;
            end else if (st_q.cnt == TAP_MAX) begin
                st_d.fin  = 1'b1;
                st_d.meas = TAP_MAX;
                sat_set   = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
        st_d.ovf = sat_set | (st_q.ovf & ~ovf_clr_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.fin <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign fin_o  = st_q.fin;
    assign meas_o = st_q.meas;
    assign ovf_o  = st_q.ovf;
endmodule

// File: rtl/dlcal_auto_timer.sv
module dlcal_auto_timer #(
    parameter int PERIOD = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    output logic tick_o
);
    localparam int CW = (PERIOD > 2) ? $clog2(PERIOD) : 1;
    localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick_o = en_i && (cnt_q == LAST);
        if (!en_i || tick_o) cnt_d = '0;
        else                 cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/dlcal_ctrl.sv
module dlcal_ctrl
    import dlcal_pkg::*;
#(
    parameter int NUM_CAL     = 4,
    parameter int ADDR_W      = 4,
    parameter int AUTO_PERIOD = 4096
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     reg_we,
    input  logic [ADDR_W-1:0]        reg_addr,
    input  logic [DATA_W-1:0]        reg_wdata,
    output logic [DATA_W-1:0]        reg_rdata,
    input  logic [NUM_CAL-1:0]       pd_in,
    output logic [NUM_CAL*TAP_W-1:0] delay_out
);
    typedef struct packed {
        ctrl_t                    ctrl;
        logic                     busy;
        tap_t [NUM_CAL-1:0]       sw;
        tap_t [NUM_CAL-1:0]       applied;
    } top_st_t;

    top_st_t st_d, st_q;

    logic                 ctrl_sel;
    logic                 sw_start_req;
    logic                 auto_tick;
    logic                 start_pulse;
    logic                 all_fin;
    logic                 cal_done;
    logic [NUM_CAL-1:0]   cal_sel;
    logic [NUM_CAL-1:0]   ovf_clr;
    logic [NUM_CAL-1:0]   fin;
    logic [NUM_CAL-1:0]   ovf;
    tap_t [NUM_CAL-1:0]   meas;

    logic                 busy_w;
    logic                 inhibit_w;
    logic                 use_sw_w;
    logic                 auto_en_w;
    logic                 unused_wbits;

    assign unused_wbits = ^{reg_wdata[DATA_W-1:OVF_BIT+1], reg_wdata[INH_BIT-1:0]};

    assign ctrl_sel     = reg_we && (reg_addr == '0);
    assign sw_start_req = ctrl_sel && reg_wdata[START_BIT];
    assign start_pulse  = !st_q.busy && (sw_start_req || auto_tick);
    assign all_fin      = &fin;
    assign cal_done     = st_q.busy && all_fin;

    dlcal_auto_timer #(
        .PERIOD (AUTO_PERIOD)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (st_q.ctrl.auto_en),
        .tick_o (auto_tick)
    );

    for (genvar g = 0; g < NUM_CAL; g++) begin : g_cal
        assign cal_sel[g] = reg_we && (reg_addr == ADDR_W'(g + 1));
        assign ovf_clr[g] = cal_sel[g] && reg_wdata[OVF_BIT];

        dlcal_tap_counter u_tc (
            .clk       (clk),
            .rst_n     (rst_n),
            .start_i   (start_pulse),
            .active_i  (st_q.busy),
            .pd_i      (pd_in[g]),
            .ovf_clr_i (ovf_clr[g]),
            .fin_o     (fin[g]),
            .meas_o    (meas[g]),
            .ovf_o     (ovf[g])
        );
    end

    always_comb begin
        st_d = st_q;

        for (int i = 0; i < NUM_CAL; i++) begin
            if (st_q.ctrl.use_sw)
                st_d.applied[i] = st_q.sw[i];
            else if (cal_done && !st_q.ctrl.inhibit)
                st_d.applied[i] = meas[i];
            if (cal_sel[i])
                st_d.sw[i] = reg_wdata[TAP_W-1:0];
        end

        if (start_pulse)   st_d.busy = 1'b1;
        else if (cal_done) st_d.busy = 1'b0;

        if (ctrl_sel) begin
            st_d.ctrl.use_sw  = reg_wdata[USESW_BIT];
            st_d.ctrl.auto_en = reg_wdata[AUTO_BIT];
            st_d.ctrl.inhibit = reg_wdata[INH_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == '0) begin
            reg_rdata[START_BIT] = st_q.busy;
            reg_rdata[USESW_BIT] = st_q.ctrl.use_sw;
            reg_rdata[AUTO_BIT]  = st_q.ctrl.auto_en;
            reg_rdata[INH_BIT]   = st_q.ctrl.inhibit;
        end
        for (int i = 0; i < NUM_CAL; i++) begin
            if (reg_addr == ADDR_W'(i + 1)) begin
                reg_rdata[MEAS_LSB +: TAP_W] = meas[i];
                reg_rdata[OVF_BIT]           = ovf[i];
                reg_rdata[TAP_W-1:0]         = st_q.sw[i];
            end
        end
    end

    assign delay_out = st_q.applied;

    assign busy_w    = st_q.busy;
    assign inhibit_w = st_q.ctrl.inhibit;
    assign use_sw_w  = st_q.ctrl.use_sw;
    assign auto_en_w = st_q.ctrl.auto_en;
endmodule

// File: rtl/dlcal_ctrl_chk.sv
module dlcal_ctrl_chk #(
    parameter int NUM_CAL = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 sw_start_req,
    input logic                 auto_tick,
    input logic                 busy,
    input logic                 all_fin,
    input logic                 inhibit,
    input logic                 use_sw,
    input logic [NUM_CAL-1:0]   ovf,
    input logic [NUM_CAL*8-1:0] delay_out
);
    // R1
    start_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_start_req && !busy) |=> busy);

    // R4
    inhibit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inhibit && !use_sw) |=> $stable(delay_out));

    // R7
    busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(all_fin));

    // R3
    auto_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(sw_start_req || auto_tick));

    // R6
    ovf_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(ovf) > $countones($past(ovf))) |-> $past(busy));
endmodule

bind dlcal_ctrl dlcal_ctrl_chk #(
    .NUM_CAL (NUM_CAL)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sw_start_req (sw_start_req),
    .auto_tick    (auto_tick),
    .busy         (busy_w),
    .all_fin      (all_fin),
    .inhibit      (inhibit_w),
    .use_sw       (use_sw_w),
    .ovf          (ovf),
    .delay_out    (delay_out)
);

// File: tb/dlcal_ctrl_bench.sv
module dlcal_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NC         = 4;
    localparam int AW         = 4;
    localparam int AUTO_P     = 256;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              reg_we = 1'b0;
    logic [AW-1:0]     reg_addr = '0;
    logic [31:0]       reg_wdata = '0;
    logic [31:0]       reg_rdata;
    logic [NC-1:0]     pd_in = '0;
    logic [NC*8-1:0]   delay_out;

    int checks = 0;
    int fails  = 0;

    dlcal_ctrl #(.NUM_CAL(NC), .ADDR_W(AW), .AUTO_PERIOD(AUTO_P)) u_dlcal_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pd_in(pd_in),
        .delay_out(delay_out));

    always #(CLK_PERIOD/2) clk = ~clk;

    // behavioural reference model
    int m_cnt[NC], m_meas[NC], m_sw[NC], m_app[NC];
    bit m_fin[NC], m_ref[NC], m_ovf[NC];
    bit m_busy, m_usesw, m_auto, m_inh;
    int m_tmr;
    bit mw0, mst, mtk, mdn, mset;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NC; i++) begin
                m_cnt[i] = 0; m_meas[i] = 0; m_sw[i] = 0; m_app[i] = 0;
                m_fin[i] = 1; m_ref[i] = 0; m_ovf[i] = 0;
            end
            m_busy = 0; m_usesw = 0; m_auto = 0; m_inh = 0; m_tmr = 0;
        end else begin
            mw0 = reg_we && (reg_addr == 0);
            mtk = m_auto && (m_tmr == AUTO_P - 1);
            mst = !m_busy && ((mw0 && reg_wdata[7]) || mtk);
            mdn = m_busy;
            for (int i = 0; i < NC; i++) mdn = mdn && m_fin[i];
            if (!m_auto || mtk) m_tmr = 0; else m_tmr = m_tmr + 1;
            for (int i = 0; i < NC; i++) begin
                if (m_usesw) m_app[i] = m_sw[i];
                else if (mdn && !m_inh) m_app[i] = m_meas[i];
                mset = 0;
                if (mst) begin
                    m_cnt[i] = 0; m_fin[i] = 0; m_ref[i] = pd_in[i];
                end else if (m_busy && !m_fin[i]) begin
                    if (pd_in[i] != m_ref[i]) begin
                        m_fin[i] = 1; m_meas[i] = m_cnt[i];
                    end else if (m_cnt[i] == 255) begin
                        m_fin[i] = 1; m_meas[i] = 255; mset = 1;
                    end else m_cnt[i] = m_cnt[i] + 1;
                end
                if (mset) m_ovf[i] = 1;
                else if (reg_we && reg_addr == AW'(i + 1) && reg_wdata[8]) m_ovf[i] = 0;
                if (reg_we && reg_addr == AW'(i + 1)) m_sw[i] = int'(reg_wdata[7:0]);
            end
            if (mst) m_busy = 1; else if (mdn) m_busy = 0;
            if (mw0) begin
                m_usesw = reg_wdata[6]; m_auto = reg_wdata[5]; m_inh = reg_wdata[4];
            end
        end
    end

    function automatic logic [31:0] model_rd(input logic [AW-1:0] a);
        logic [31:0] v = '0;
        if (a == 0) v = {24'd0, m_busy, m_usesw, m_auto, m_inh, 4'd0};
        else if (a <= NC) v = {8'(m_meas[a-1]), 15'd0, m_ovf[a-1], 8'(m_sw[a-1])};
        return v;
    endfunction

    function automatic logic [NC*8-1:0] model_dly();
        logic [NC*8-1:0] v;
        for (int i = 0; i < NC; i++) v[i*8 +: 8] = 8'(m_app[i]);
        return v;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // per-clock comparison against the model, away from the edge
    always @(posedge clk) begin
        #(CLK_PERIOD/4);
        if (rst_n) begin
            chk("R1/R5 register read vs model", reg_rdata, model_rd(reg_addr));
            chk("R7 delay_out vs model", delay_out, model_dly());
        end
    end

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_we = 0; reg_addr = 0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
        @(negedge clk); reg_we = 0; reg_addr = a;
        #1 d = reg_rdata;
    endtask

    int tgl[NC];
    logic [31:0] cur_ctrl = 0;
    bit saw_busy;

    task automatic run_cal(input int restart_at);
        @(negedge clk); reg_we = 1; reg_addr = 0; reg_wdata = cur_ctrl | 32'h80;
        saw_busy = 0;
        for (int c = 1; c < 400; c++) begin
            @(negedge clk); reg_we = 0; reg_addr = 0;
            if (c == restart_at) begin reg_we = 1; reg_wdata = cur_ctrl | 32'h80; end
            for (int i = 0; i < NC; i++) if (tgl[i] == c) pd_in[i] = ~pd_in[i];
            #1;
            if (c == 1 && reg_rdata[7]) saw_busy = 1;
            if (!reg_rdata[7]) break;
        end
        @(negedge clk); reg_we = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog all requirements actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] d;
        int n, rises;
        bit prev;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R10 reset state
        for (int a = 0; a <= NC; a++) begin
            rd(AW'(a), d); chk("R10 reset register", d, 0);
        end
        chk("R10 reset delay_out", delay_out, 0);

        // R1 R5 R7 basic calibration
        tgl = '{5, 10, 1, 20};
        run_cal(0);
        chk("R1 busy seen after start", {31'd0, saw_busy}, 1);
        rd(0, d); chk("R1 start bit cleared", d, 0);
        rd(1, d); chk("R5 cal0 count", d, 32'h0400_0000);
        rd(2, d); chk("R5 cal1 count", d, 32'h0900_0000);
        rd(3, d); chk("R5 cal2 first-cycle change", d, 32'h0000_0000);
        rd(4, d); chk("R5 cal3 count", d, 32'h1300_0000);
        chk("R7 applied after completion", delay_out, 32'h1300_0904);

        // R9 restart ignored
        tgl = '{40, 40, 40, 40};
        run_cal(10);
        rd(1, d); chk("R9 start while busy ignored", d, 32'h2700_0000);
        chk("R9 applied from unrestarted run", delay_out, 32'h2727_2727);

        // R4 inhibit
        cur_ctrl = 32'h10; wr(0, cur_ctrl);
        tgl = '{30, 31, 32, 33};
        run_cal(0);
        rd(4, d); chk("R4 measurement still reported", d, 32'h2000_0000);
        chk("R4 applied unchanged under inhibit", delay_out, 32'h2727_2727);

        // R2 software delay
        wr(1, 32'h11); wr(2, 32'h22); wr(3, 32'h33); wr(4, 32'h44);
        cur_ctrl = 32'h40; wr(0, cur_ctrl);
        @(negedge clk);
        chk("R2 software delay applied", delay_out, 32'h4433_2211);
        tgl = '{3, 3, 3, 3};
        run_cal(0);
        chk("R2 calibration does not override", delay_out, 32'h4433_2211);
        rd(1, d); chk("R2 count still measured", d, 32'h0200_0011);

        // R6 saturation and sticky overflow
        cur_ctrl = 0; wr(0, cur_ctrl);
        tgl = '{7, 0, 7, 7};
        run_cal(0);
        rd(2, d); chk("R6 saturated count and flag", d, 32'hFF00_0122);
        rd(1, d); chk("R6 no flag on normal count", d, 32'h0600_0011);
        chk("R7 applied incl saturated", delay_out, 32'h0606_FF06);
        wr(2, 32'h22); rd(2, d); chk("R6 flag sticky on write of 0", d, 32'hFF00_0122);
        wr(2, 32'h122); rd(2, d); chk("R6 flag cleared by write of 1", d, 32'hFF00_0022);

        // R8 automatic period
        cur_ctrl = 32'h20; wr(0, cur_ctrl);
        n = 0;
        #1;
        while (!reg_rdata[7] && n < 2000) begin @(negedge clk); n++; #1; end
        chk("R8 first automatic start at period", n, AUTO_P);
        rises = 0; prev = 1;
        for (int k = 0; k < 1200 - AUTO_P; k++) begin
            @(negedge clk); #1;
            if (reg_rdata[7] && !prev) rises++;
            prev = reg_rdata[7];
        end
        chk("R8 request dropped while busy", rises, 1);

        // R3 disable stops automatic starts
        cur_ctrl = 0; wr(0, cur_ctrl);
        repeat (300) @(negedge clk);
        rises = 0;
        for (int k = 0; k < 3 * AUTO_P; k++) begin
            @(negedge clk); #1;
            if (reg_rdata[7]) rises++;
        end
        chk("R3 no automatic start when disabled", rises, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule